// File: doc/BRIEF.md
# Half-Duplex Two-Wire Serial Slave Port

This block is the device side of a serial link in which a single data pin carries traffic in both directions. A host sends a 16-bit write word into the device, and the same pin then turns around so that the device can return a 16-bit read word. The host provides a serial clock and an active-low frame input. The shared pin appears at the block's edge as three signals: an input, an output and an output enable. A pad cell outside the block merges them.

All serial inputs are resynchronised into one system clock, and the serial-clock edges are detected in that domain. A polarity input selects which serial-clock edge samples data and which edge shifts data out. A captured write word is handed on with a one-cycle strobe. Each outgoing read word is fetched from the register side with a one-cycle request strobe, and `rd_data_i` must hold the word while that request is high.

A write word can open a calibration burst. In a burst, a fixed number of words moves in one direction, and the pin direction does not change until the last of those words has moved. A burst cannot be cut short by the frame input.

Top module: `hdx_serial_port`

## Requirements
- R1: Write words are sampled most significant bit first, one bit on each sample edge while the frame is low. A completed word whose mode bit (bit 1) is 1 gives a one-cycle `wr_valid_o` with `wr_cal_o` = 0 and the full word on `wr_data_o`.
- R2: A completed write word whose mode bit is 0 gives no `wr_valid_o`, outside a burst. The pin still turns to output.
- R3: On the 16th sample edge of a write word, outside a calibration write burst, the direction becomes output and `rd_req_o` pulses once. While the frame is low, `doe_o` is then 1.
- R4: In a read word, the first shift edge puts bit 15 on `dout_o`, and each later shift edge puts the next lower bit there. After the 16th sample edge the direction returns to input and `doe_o` falls.
- R5: While the frame is high, `doe_o` is 0 in either direction. When the frame goes low again in the output direction, `doe_o` returns to 1.
- R6: With the frame held low, write and read words alternate every 16 sample edges. `doe_o` stays 1 from the end of the write until the end of the read.
- R7: With `pol_i` = 1, the rising serial-clock edge samples and the falling edge shifts out. With `pol_i` = 0 the two roles swap.
- R8: Raising the frame in the middle of a word keeps the bit count. Outside a burst, the next falling frame edge restarts the count at zero, so a complete new word is captured.
- R9: A mode-valid write word with bit 15 = 1, bit 14 = 1 and bits 13:12 = k is a calibration read command. After its strobe, k+1 read words follow, each fetched by its own `rd_req_o`. The pin stays output until the last of them has been sent, and then returns to input.
- R10: A mode-valid write word with bit 15 = 1, bit 14 = 0 and bits 13:12 = k is a calibration write command. The next k+1 words are received with the pin as input. Each of them is strobed with `wr_cal_o` = 1, whatever its mode bit. `rd_req_o` pulses only after the last of them, when the pin turns to output.
- R11: A high frame during a burst does not end the burst. The bit count is kept, and the word in progress completes correctly once the frame is low again.
- R12: After reset, the direction is input, and `doe_o`, `wr_valid_o` and `rd_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| frame_n_i | input | 1 | Active-low frame from the host |
| pol_i | input | 1 | Edge polarity select (1: rising edge samples) |
| din_i | input | 1 | Shared pin, input side |
| dout_o | output | 1 | Shared pin, output side |
| doe_o | output | 1 | Shared pin, output enable |
| wr_valid_o | output | 1 | One-cycle strobe for a received word |
| wr_data_o | output | WORD_W | Received word |
| wr_cal_o | output | 1 | Received word is calibration burst data |
| rd_req_o | output | 1 | One-cycle request for the next outgoing word |
| rd_data_i | input | WORD_W | Outgoing word, valid while `rd_req_o` is high |

## Verification
Every serial input goes through two synchroniser stages and one edge register before it changes state. A write strobe or read request therefore appears about four system cycles after the sample edge that causes it. A new `dout_o` bit appears about four cycles after a shift edge, and `doe_o` follows a frame change after about three cycles.

The bench keeps each serial half-period at six system cycles. It reads `dout_o` on the falling system-clock edge just before it drives the next sample edge. It checks strobe counters and `doe_o` only after a further settling wait of four to six cycles. Expected read words come from a bench function of the request index, so any missing or extra `rd_req_o` pulse shows up as wrong data.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    // Direction of the shared data pin.
    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dir_e;

    // Field positions inside a write command word.
    localparam int MODE_BIT_POS = 1;   // must be 1 for a normal word to be accepted
    localparam int CAL_EN_POS   = 15;  // opens a calibration burst
    localparam int CAL_RD_POS   = 14;  // 1: read burst, 0: write burst
    localparam int CAL_CNT_LSB  = 12;  // burst length minus one
    localparam int CAL_CNT_W    = 2;

endpackage

// File: rtl/hdx_sync.sv
module hdx_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hdx_edge.sv
module hdx_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise[b] =  lvl[b] & ~prev_q[b];
        assign fall[b] = ~lvl[b] &  prev_q[b];
    end
endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port
    import hdx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MODE_BIT    = MODE_BIT_POS,
    parameter int CAL_EN_BIT  = CAL_EN_POS,
    parameter int CAL_RD_BIT  = CAL_RD_POS,
    parameter int CNT_LSB     = CAL_CNT_LSB,
    parameter int CNT_FIELD_W = CAL_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              frame_n_i,
    input  logic              pol_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              doe_o,
    output logic              wr_valid_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              wr_cal_o,
    output logic              rd_req_o,
    input  logic [WORD_W-1:0] rd_data_i
);
    localparam int                CNT_W   = $clog2(WORD_W);
    localparam int                BURST_W = CNT_FIELD_W + 1;
    localparam logic [CNT_W-1:0]  LAST    = CNT_W'(WORD_W - 1);
    localparam logic [BURST_W-1:0] ONE    = BURST_W'(1);

    typedef struct packed {
        dir_e               dir;
        logic [CNT_W-1:0]   cnt;
        logic [WORD_W-1:0]  sh;
        logic               dout;
        logic [BURST_W-1:0] left;
        logic               burst;
        logic               wr_v;
        logic [WORD_W-1:0]  wr_d;
        logic               wr_cal;
        logic               rd_req;
    } state_t;

    state_t q, d;

    // ---------------------------------------------------------------
    // Synchronise and detect edges. Vector order: {pol, din, frame_n, sclk}.
    // ---------------------------------------------------------------
    logic [3:0] raw_in, syn;
    logic       sclk_s, frame_s, din_s, pol_s;
    logic [1:0] rise_v, fall_v;
    logic       frame_rise_unused;

    assign raw_in = {pol_i, din_i, frame_n_i, sclk_i};

    hdx_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    assign sclk_s  = syn[0];
    assign frame_s = syn[1];
    assign din_s   = syn[2];
    assign pol_s   = syn[3];

    hdx_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({frame_s, sclk_s}),
        .rise  (rise_v),
        .fall  (fall_v)
    );

    logic frame_fall, active, smp_edge, shf_edge;
    assign frame_rise_unused = rise_v[1];
    assign frame_fall = fall_v[1];
    assign active     = ~frame_s;
    assign smp_edge   = pol_s ? rise_v[0] : fall_v[0];
    assign shf_edge   = pol_s ? fall_v[0] : rise_v[0];

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    logic [WORD_W-1:0] word;
    assign word = {q.sh[WORD_W-2:0], din_s};

    always_comb begin
        d        = q;
        d.wr_v   = 1'b0;
        d.rd_req = 1'b0;

        if (frame_fall && !q.burst) begin
            d.cnt = '0;
        end else if (active) begin
            if (q.dir == DIR_IN) begin
                if (smp_edge) begin
                    d.sh  = word;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (q.burst) begin
                            // calibration data word: taken whatever its mode bit
                            d.wr_v   = 1'b1;
                            d.wr_d   = word;
                            d.wr_cal = 1'b1;
                            d.left   = q.left - ONE;
                            if (q.left == ONE) begin
                                d.burst  = 1'b0;
                                d.dir    = DIR_OUT;
                                d.rd_req = 1'b1;
                            end
                        end else if (word[MODE_BIT]) begin
                            d.wr_v   = 1'b1;
                            d.wr_d   = word;
                            d.wr_cal = 1'b0;
                            if (word[CAL_EN_BIT]) begin
                                d.burst = 1'b1;
                                d.left  = BURST_W'(word[CNT_LSB +: CNT_FIELD_W]) + ONE;
                                if (word[CAL_RD_BIT]) begin
                                    d.dir    = DIR_OUT;
                                    d.rd_req = 1'b1;
                                end
                            end else begin
                                d.dir    = DIR_OUT;
                                d.rd_req = 1'b1;
                            end
                        end else begin
                            // rejected word: the pin still turns around
                            d.dir    = DIR_OUT;
                            d.rd_req = 1'b1;
                        end
                    end
                end
            end else begin
                if (shf_edge) begin
                    d.dout = q.sh[WORD_W-1];
                    d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                end
                if (smp_edge) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (q.burst && q.left != ONE) begin
                            d.left   = q.left - ONE;
                            d.rd_req = 1'b1;
                        end else begin
                            d.burst = 1'b0;
                            d.left  = '0;
                            d.dir   = DIR_IN;
                        end
                    end
                end
            end
        end

        // The outgoing word is taken while the request is high.
        if (q.rd_req) begin
            d.sh = rd_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout_o     = q.dout;
    assign doe_o      = active & (q.dir == DIR_OUT);
    assign wr_valid_o = q.wr_v;
    assign wr_data_o  = q.wr_d;
    assign wr_cal_o   = q.wr_cal;
    assign rd_req_o   = q.rd_req;

    // Internal views for the bound checker
    logic             dir_out_w;
    logic             burst_w;
    logic [CNT_W-1:0] cnt_w;
    assign dir_out_w = (q.dir == DIR_OUT);
    assign burst_w   = q.burst;
    assign cnt_w     = q.cnt;

endmodule

// File: rtl/hdx_serial_port_chk.sv
module hdx_serial_port_chk #(
    parameter int WORD_W   = 16,
    parameter int MODE_BIT = 1,
    parameter int CNT_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid_o,
    input logic              wr_cal_o,
    input logic [WORD_W-1:0] wr_data_o,
    input logic              rd_req_o,
    input logic              doe_o,
    input logic              dir_out,
    input logic              burst_on,
    input logic              frame_fall,
    input logic [CNT_W-1:0]  cnt
);
    // R2
    mode_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_cal_o) |-> wr_data_o[MODE_BIT]);

    // R3
    req_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> dir_out);

    // R5
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doe_o |-> dir_out);

    // R11
    burst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_on && $past(burst_on)) |-> $stable(dir_out));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_fall && !burst_on) |=> (cnt == '0));

    // R10
    cal_wr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_cal_o && burst_on) |-> !rd_req_o);
endmodule

bind hdx_serial_port hdx_serial_port_chk #(
    .WORD_W   (WORD_W),
    .MODE_BIT (MODE_BIT),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_o (wr_valid_o),
    .wr_cal_o   (wr_cal_o),
    .wr_data_o  (wr_data_o),
    .rd_req_o   (rd_req_o),
    .doe_o      (doe_o),
    .dir_out    (dir_out_w),
    .burst_on   (burst_w),
    .frame_fall (frame_fall),
    .cnt        (cnt_w)
);

// File: tb/sim_hdx_serial_port.sv
`timescale 1ns/1ps
module sim_hdx_serial_port;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b1;
    logic        frame_n_i = 1'b1;
    logic        pol_i = 1'b1;
    logic        din_i = 1'b0;
    logic        dout_o, doe_o, wr_valid_o, wr_cal_o, rd_req_o;
    logic [15:0] wr_data_o, rd_data_i;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // monitors
    int          wr_cnt = 0;
    logic [15:0] wr_last = '0;
    logic        wr_last_cal = 1'b0;
    int          req_cnt = 0;
    int          exp_req = 0;
    int          exp_wr  = 0;

    always #10 clk = ~clk;   // 50 MHz

    hdx_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .frame_n_i(frame_n_i),
        .pol_i(pol_i), .din_i(din_i), .dout_o(dout_o), .doe_o(doe_o),
        .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_cal_o(wr_cal_o),
        .rd_req_o(rd_req_o), .rd_data_i(rd_data_i)
    );

    function automatic logic [15:0] rd_word(input int n);
        logic [31:0] v;
        v = 32'h0000B3C5 ^ (32'(n) * 32'h00002F1D);
        return v[15:0];
    endfunction

    assign rd_data_i = rd_word(req_cnt);

    always @(posedge clk) begin
        if (wr_valid_o) begin
            wr_cnt      <= wr_cnt + 1;
            wr_last     <= wr_data_o;
            wr_last_cal <= wr_cal_o;
        end
        if (rd_req_o) req_cnt <= req_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bitc(input logic b, output logic o);
        @(negedge clk);
        sclk_i = ~pol_i;
        din_i  = b;
        repeat (HALF) @(negedge clk);
        o      = dout_o;
        sclk_i = pol_i;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        logic o;
        for (int i = 15; i >= 0; i--) bitc(w[i], o);
        repeat (4) @(negedge clk);
    endtask

    task automatic read_part(input int hi, input int lo, inout logic [15:0] r);
        logic o;
        for (int i = hi; i >= lo; i--) begin
            bitc(1'b0, o);
            r[i] = o;
        end
    endtask

    task automatic frame_low();
        @(negedge clk);
        frame_n_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic frame_high();
        @(negedge clk);
        frame_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic set_pol(input logic p);
        @(negedge clk);
        pol_i  = p;
        sclk_i = p;
        repeat (6) @(negedge clk);
    endtask

    // one normal write followed by its read; tied selects frame held low
    task automatic write_read(input logic [15:0] w, input bit tied, input string tag);
        logic [15:0] r;
        r = '0;
        frame_low();
        write_word(w);
        exp_req++;
        if (w[1]) begin
            exp_wr++;
            chk({tag, " R1 word"}, 32'(wr_last), 32'(w));
            chk({tag, " R1 cal flag"}, 32'(wr_last_cal), 32'd0);
        end
        chk({tag, " R1/R2 strobe count"}, 32'(wr_cnt), 32'(exp_wr));
        chk({tag, " R3 request count"}, 32'(req_cnt), 32'(exp_req));
        if (tied) begin
            chk({tag, " R6 no tri-state at turnaround"}, 32'(doe_o), 32'd1);
        end else begin
            frame_high();
            chk({tag, " R5 tri-state while frame high"}, 32'(doe_o), 32'd0);
            frame_low();
            chk({tag, " R5 drive after frame low"}, 32'(doe_o), 32'd1);
        end
        read_part(15, 0, r);
        repeat (4) @(negedge clk);
        chk({tag, " R4 read word"}, 32'(r), 32'(rd_word(exp_req - 1)));
        chk({tag, " R4 back to input"}, 32'(doe_o), 32'd0);
        frame_high();
    endtask

    initial begin
        logic [15:0] w, r;
        logic        o;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        chk("R12 doe after reset", 32'(doe_o), 32'd0);
        chk("R12 wr_valid after reset", 32'(wr_valid_o), 32'd0);
        chk("R12 rd_req after reset", 32'(rd_req_o), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R12 doe idle", 32'(doe_o), 32'd0);
        chk("R12 no request", 32'(req_cnt), 32'd0);

        // directed: both polarities, pulsed frame (R7)
        write_read(16'h3C5A, 1'b0, "R7 pol1");
        set_pol(1'b0);
        write_read(16'h0F0E, 1'b0, "R7 pol0");
        set_pol(1'b1);

        // R2 rejected word
        write_read(16'h7FFD, 1'b0, "R2 reject");

        // R6 frame tied low over two exchanges
        frame_low();
        for (int k = 0; k < 2; k++) begin
            w = 16'h1236 + 16'(k);
            write_word(w);
            exp_req++; exp_wr++;
            chk("R6 tied word", 32'(wr_last), 32'(w));
            chk("R6 no tri-state at turnaround", 32'(doe_o), 32'd1);
            r = '0;
            read_part(15, 0, r);
            repeat (4) @(negedge clk);
            chk("R6 tied read", 32'(r), 32'(rd_word(exp_req - 1)));
            chk("R6 pin input after read", 32'(doe_o), 32'd0);
        end
        frame_high();

        // R8 abandoned partial word, then a full word
        frame_low();
        for (int i = 0; i < 5; i++) bitc(1'b1, o);
        frame_high();
        chk("R8 no strobe from partial word", 32'(wr_cnt), 32'(exp_wr));
        write_read(16'h2462, 1'b0, "R8 restart");

        // R9 calibration read burst, k=2 -> 3 words, frame break mid word (R11)
        w = 16'hE0A6;                        // bit15=1 bit14=1 bits13:12=2 bit1=1
        frame_low();
        write_word(w);
        exp_req++; exp_wr++;
        chk("R9 command strobe", 32'(wr_last), 32'(w));
        chk("R9 command not cal data", 32'(wr_last_cal), 32'd0);
        for (int n = 0; n < 3; n++) begin
            r = '0;
            if (n == 1) begin
                read_part(15, 8, r);
                frame_high();
                chk("R11 tri-state during burst", 32'(doe_o), 32'd0);
                frame_low();
                chk("R11 drive resumes", 32'(doe_o), 32'd1);
                read_part(7, 0, r);
            end else begin
                read_part(15, 0, r);
            end
            repeat (4) @(negedge clk);
            chk("R9 burst word data", 32'(r), 32'(rd_word(exp_req - 1)));
            chk("R9 request per word", 32'(req_cnt), 32'(exp_req + ((n < 2) ? 1 : 0)));
            if (n < 2) begin
                exp_req++;
                chk("R9 pin stays output", 32'(doe_o), 32'd1);
            end
        end
        chk("R9 pin input after burst", 32'(doe_o), 32'd0);
        frame_high();

        // R10 calibration write burst, k=1 -> 2 words, mode bit 0 in data
        w = 16'h9002;                        // bit15=1 bit14=0 bits13:12=1 bit1=1
        frame_low();
        write_word(w);
        exp_wr++;
        chk("R10 command strobe", 32'(wr_cnt), 32'(exp_wr));
        chk("R10 no request after command", 32'(req_cnt), 32'(exp_req));
        chk("R10 pin input", 32'(doe_o), 32'd0);
        for (int n = 0; n < 2; n++) begin
            w = 16'h4440 + 16'(n * 8);       // bit1=0
            write_word(w);
            exp_wr++;
            chk("R10 data captured", 32'(wr_last), 32'(w));
            chk("R10 cal flag", 32'(wr_last_cal), 32'd1);
            if (n == 0) chk("R10 no request mid burst", 32'(req_cnt), 32'(exp_req));
        end
        exp_req++;
        chk("R10 request after last", 32'(req_cnt), 32'(exp_req));
        chk("R10 pin output", 32'(doe_o), 32'd1);
        r = '0;
        read_part(15, 0, r);
        repeat (4) @(negedge clk);
        chk("R10 following read", 32'(r), 32'(rd_word(exp_req - 1)));
        frame_high();

        // constrained random
        for (int it = 0; it < 20; it++) begin
            logic p;
            bit   tied;
            p    = 1'($urandom);
            tied = bit'($urandom);
            w    = 16'($urandom);
            w[15] = 1'b0;
            w[1]  = ($urandom % 4) != 0;
            set_pol(p);
            write_read(w, tied, "R1 random");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule